// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper Controller

This block is the bank controller of an 8-bit console cartridge. On the CPU side it observes the address bus, the data bus and a one-cycle write strobe. Writes in the upper half of the CPU map, $8000-$FFFF, load its bank and control registers. From those registers it drives three things: the upper program-ROM address lines for each 8 KB CPU window, the upper character-ROM address lines for each 1 KB video-memory page, and the nametable select bit that sets mirroring. The write-strobe qualification, register decode and register state are clocked. The bank and mirroring outputs are combinational from the live bus addresses and the stored registers.

Boards connect the two register-select inputs to different CPU address bits, so the select bits are parameters. A legacy option ORs a second, alternate address bit into each select input. Another parameter picks between two chip variants. The basic variant has two-way mirroring only, and a one-bit latch in the $6000-$6FFF window. The extended variant adds one-screen mirroring and a swap mode that moves the switchable program bank from $8000 to $C000. It also decodes $6000-$6FFF as a 2 KB work-RAM window. A further parameter makes a character-bank value select bank (value >> 1), which matches one board variant. An optional setting stops a full $FF mirroring write from selecting a one-screen mode.

Top module: `bank_mapper`

## Requirements
- R1: After reset all bank registers, the mirroring mode and the swap mode are 0. With a 5-bit program bank, the window outputs for CPU A14:13 = 0,1,2,3 are then 0, 0, 30 and 31, every character page reads bank 0, and `ciram_a10` follows PPU A10.
- R2: A write in $8xxx loads program register P0, and a write in $Axxx loads register P1, each from data bits [4:0]. With swap off the window outputs are P0 at $8000, P1 at $A000, the second-to-last bank (30) at $C000 and the last bank (31) at $E000. The $E000 window always shows bank 31.
- R3: On the extended variant, a write in $9xxx with select = 2 or 3 sets the swap mode from data bit 1. With swap on, $8000 shows bank 30 and $C000 shows P0. On the basic variant the same write does not change the program mapping.
- R4: Character page p (0..7) has its register in group $B,$C,$D,$E = (p>>1)+3, with select bit 1 = p&1. Select bit 0 = 0 writes the low nibble from data[3:0], and select bit 0 = 1 writes the high nibble from data[3:0]. The `chr_bank` output shows the register of the page selected by PPU A12:10.
- R5: With the shift option on, `chr_bank` equals the page register shifted right by one bit.
- R6: Select bit 0 and select bit 1 come from the CPU address bits named by the parameters; all other low address bits are ignored. In legacy mode each select bit is the OR of its main bit and its alternate bit.
- R7: Mirroring mode encoding: 0 = vertical (`ciram_a10` = PPU A10), 1 = horizontal (`ciram_a10` = PPU A11), 2 = one-screen low (0), 3 = one-screen high (1). On the extended variant, a write in $9xxx with select 0 or 1 loads the mode from data[1:0].
- R8: On the basic variant the mirroring mode is loaded from data bit 0 only, so only vertical and horizontal can be selected.
- R9: With the compatibility option on, a mirroring write of exactly $FF selects horizontal (mode 1). Any other value with data bit 1 set selects a one-screen mode.
- R10: On the extended variant `wram_ce` is 1 exactly when CPU A15:12 = $6, and `wram_addr` equals CPU A10:0. On the basic variant `wram_ce` is 0.
- R11: On the basic variant a write in $6000-$6FFF stores data bit 0 in the latch. A read in that range sets `latch_oe` and returns the stored bit on `latch_bit`. Accesses in $7000-$7FFF neither change the latch nor enable it.
- R12: Writes below $8000 and writes in $Fxxx leave every bank, mirroring and swap setting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| ppu_addr | input | 14 | Video-memory address bus |
| prg_bank | output | PRG_W | Program-ROM bank for the current CPU window |
| chr_bank | output | CHR_W | Character-ROM bank for the current 1 KB page |
| ciram_a10 | output | 1 | Nametable select bit |
| wram_ce | output | 1 | Work-RAM enable (extended variant) |
| wram_addr | output | 11 | Work-RAM address |
| latch_oe | output | 1 | Latch read enable (basic variant) |
| latch_bit | output | 1 | Latch read data on data bit 0 |

## Verification
The assertions assume three things about the inputs. `cpu_wr` is high for exactly one clock per CPU write. Address and data are stable around the rising edge on which the write is taken. Only the strobe qualifies a write, so any value on the unused address bits is legal. The bench changes bus signals only on falling edges and holds each write for a single cycle. Its random writes fill every address bit that is not a select or group bit with random noise, so the rule that non-select bits are ignored is exercised under these same assumptions.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int NUM_CHR = 8;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  // Register groups from CPU A14:12 inside $8000-$FFFF
  localparam logic [2:0] GRP_PRG0 = 3'd0;
  localparam logic [2:0] GRP_CTRL = 3'd1;
  localparam logic [2:0] GRP_PRG1 = 3'd2;
  localparam logic [2:0] GRP_CHR0 = 3'd3;
  localparam logic [2:0] GRP_CHR3 = 3'd6;
endpackage

// File: rtl/bank_mapper_regsel.sv
module bank_mapper_regsel #(
  parameter int SEL_LO_BIT  = 2,
  parameter int SEL_HI_BIT  = 3,
  parameter bit LEGACY_OR   = 1'b0,
  parameter int SEL_LO_ALT  = 6,
  parameter int SEL_HI_ALT  = 7
) (
  input  logic [15:0] addr,
  output logic [1:0]  sel
);
  logic unused_addr;
  assign unused_addr = ^addr;

  generate
    if (LEGACY_OR) begin : g_or
      assign sel = {addr[SEL_HI_BIT] | addr[SEL_HI_ALT],
                    addr[SEL_LO_BIT] | addr[SEL_LO_ALT]};
    end else begin : g_direct
      assign sel = {addr[SEL_HI_BIT], addr[SEL_LO_BIT]};
    end
  endgenerate
endmodule

// File: rtl/bank_mapper_regfile.sv
module bank_mapper_regfile
  import bank_mapper_pkg::*;
#(
  parameter bit EXTENDED    = 1'b1,
  parameter bit MIRROR_HACK = 1'b1,
  parameter int PRG_W       = 5,
  parameter int CHR_W       = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [2:0]                     grp,
  input  logic [1:0]                     sel,
  input  logic [7:0]                     data,
  output logic [PRG_W-1:0]               prg0_q,
  output logic [PRG_W-1:0]               prg1_q,
  output logic                           swap_q,
  output mirror_e                        mode_q,
  output logic [NUM_CHR-1:0][CHR_W-1:0]  chr_q
);
  localparam int HI_W = CHR_W - 4;

  logic [PRG_W-1:0]              prg0_d, prg1_d;
  logic                          swap_d;
  mirror_e                       mode_d;
  logic [NUM_CHR-1:0][CHR_W-1:0] chr_d;
  logic [2:0]                    grp_off;
  logic [2:0]                    page_idx;

  assign grp_off  = grp - GRP_CHR0;
  assign page_idx = {grp_off[1:0], sel[1]};

  function automatic mirror_e decode_mirror(input logic [7:0] d);
    if (!EXTENDED)                       return mirror_e'({1'b0, d[0]});
    else if (MIRROR_HACK && d == 8'hFF)  return mirror_e'({1'b0, d[0]});
    else                                 return mirror_e'(d[1:0]);
  endfunction

  // next state
  always_comb begin
    prg0_d = prg0_q;
    prg1_d = prg1_q;
    swap_d = swap_q;
    mode_d = mode_q;
    chr_d  = chr_q;
    if (grp == GRP_PRG0) begin
      prg0_d = data[PRG_W-1:0];
    end else if (grp == GRP_PRG1) begin
      prg1_d = data[PRG_W-1:0];
    end else if (grp == GRP_CTRL) begin
      if (!sel[1])       mode_d = decode_mirror(data);
      else if (EXTENDED) swap_d = data[1];
    end else if (grp >= GRP_CHR0 && grp <= GRP_CHR3) begin
      if (!sel[0]) chr_d[page_idx][3:0]       = data[3:0];
      else         chr_d[page_idx][CHR_W-1:4] = data[HI_W-1:0];
    end
  end

  // registers with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg0_q <= '0;
      prg1_q <= '0;
      swap_q <= 1'b0;
      mode_q <= MIR_VERT;
      chr_q  <= '0;
    end else if (wr_en) begin
      prg0_q <= prg0_d;
      prg1_q <= prg1_d;
      swap_q <= swap_d;
      mode_q <= mode_d;
      chr_q  <= chr_d;
    end
  end

  // R12: no write strobe, no change
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(prg0_q) && $stable(prg1_q) && $stable(swap_q)
                && $stable(mode_q) && $stable(chr_q)));

  // R9: a full $FF mirroring write never lands in a one-screen mode
  p_ff_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (MIRROR_HACK && wr_en && grp == GRP_CTRL && !sel[1] && data == 8'hFF)
      |=> !mode_q[1]);

  generate
    if (EXTENDED) begin : g_swap_chk
      // R3: swap bit follows data bit 1 of a mode write
      p_swap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_CTRL && sel[1]) |=> swap_q == $past(data[1]));
    end
  endgenerate
endmodule

// File: rtl/bank_mapper_prg_map.sv
module bank_mapper_prg_map #(
  parameter int PRG_W = 5
) (
  input  logic [1:0]       slot,
  input  logic [PRG_W-1:0] prg0,
  input  logic [PRG_W-1:0] prg1,
  input  logic             swap,
  output logic [PRG_W-1:0] bank
);
  localparam logic [PRG_W-1:0] LAST_BANK   = '1;
  localparam logic [PRG_W-1:0] SECOND_LAST = LAST_BANK - 1'b1;

  always_comb begin
    case (slot)
      2'd0:    bank = swap ? SECOND_LAST : prg0;
      2'd1:    bank = prg1;
      2'd2:    bank = swap ? prg0 : SECOND_LAST;
      default: bank = LAST_BANK;
    endcase
  end
endmodule

// File: rtl/bank_mapper_chr_map.sv
module bank_mapper_chr_map
  import bank_mapper_pkg::*;
#(
  parameter int CHR_W     = 8,
  parameter bit CHR_SHIFT = 1'b0
) (
  input  logic [2:0]                    page,
  input  logic                          ppu_a10,
  input  logic                          ppu_a11,
  input  logic [NUM_CHR-1:0][CHR_W-1:0] chr_regs,
  input  mirror_e                       mode,
  output logic [CHR_W-1:0]              chr_bank,
  output logic                          ciram_a10
);
  logic [CHR_W-1:0] raw;
  assign raw = chr_regs[page];

  generate
    if (CHR_SHIFT) begin : g_shift
      assign chr_bank = {1'b0, raw[CHR_W-1:1]};
    end else begin : g_plain
      assign chr_bank = raw;
    end
  endgenerate

  always_comb begin
    case (mode)
      MIR_VERT:   ciram_a10 = ppu_a10;
      MIR_HORZ:   ciram_a10 = ppu_a11;
      MIR_ONE_LO: ciram_a10 = 1'b0;
      default:    ciram_a10 = 1'b1;
    endcase
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter bit EXTENDED    = 1'b1,
  parameter bit MIRROR_HACK = 1'b1,
  parameter bit CHR_SHIFT   = 1'b0,
  parameter bit LEGACY_OR   = 1'b0,
  parameter bit LATCH_EN    = 1'b1,
  parameter int SEL_LO_BIT  = 2,
  parameter int SEL_HI_BIT  = 3,
  parameter int SEL_LO_ALT  = 6,
  parameter int SEL_HI_ALT  = 7,
  parameter int PRG_W       = 5,
  parameter int CHR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_data,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [13:0]      ppu_addr,
  output logic [PRG_W-1:0] prg_bank,
  output logic [CHR_W-1:0] chr_bank,
  output logic             ciram_a10,
  output logic             wram_ce,
  output logic [10:0]      wram_addr,
  output logic             latch_oe,
  output logic             latch_bit
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic                          reg_wr;
  logic                          win_6k;
  logic [1:0]                    sel;
  logic [PRG_W-1:0]              prg0, prg1;
  logic                          swap;
  mirror_e                       mode;
  logic [NUM_CHR-1:0][CHR_W-1:0] chr_regs;
  logic                          unused_top;

  assign reg_wr     = cpu_wr & cpu_addr[15];
  assign win_6k     = (cpu_addr[15:12] == 4'h6);
  assign wram_addr  = cpu_addr[10:0];
  assign unused_top = ^{cpu_rd, ppu_addr[13], ppu_addr[9:0], cpu_addr[11]};

  bank_mapper_regsel #(
    .SEL_LO_BIT(SEL_LO_BIT), .SEL_HI_BIT(SEL_HI_BIT), .LEGACY_OR(LEGACY_OR),
    .SEL_LO_ALT(SEL_LO_ALT), .SEL_HI_ALT(SEL_HI_ALT)
  ) u_regsel (
    .addr(cpu_addr),
    .sel (sel)
  );

  bank_mapper_regfile #(
    .EXTENDED(EXTENDED), .MIRROR_HACK(MIRROR_HACK), .PRG_W(PRG_W), .CHR_W(CHR_W)
  ) u_regfile (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (reg_wr),
    .grp   (cpu_addr[14:12]),
    .sel   (sel),
    .data  (cpu_data),
    .prg0_q(prg0),
    .prg1_q(prg1),
    .swap_q(swap),
    .mode_q(mode),
    .chr_q (chr_regs)
  );

  bank_mapper_prg_map #(.PRG_W(PRG_W)) u_prg_map (
    .slot(cpu_addr[14:13]),
    .prg0(prg0),
    .prg1(prg1),
    .swap(swap),
    .bank(prg_bank)
  );

  bank_mapper_chr_map #(.CHR_W(CHR_W), .CHR_SHIFT(CHR_SHIFT)) u_chr_map (
    .page     (ppu_addr[12:10]),
    .ppu_a10  (ppu_addr[10]),
    .ppu_a11  (ppu_addr[11]),
    .chr_regs (chr_regs),
    .mode     (mode),
    .chr_bank (chr_bank),
    .ciram_a10(ciram_a10)
  );

  generate
    if (EXTENDED) begin : g_wram
      assign wram_ce   = win_6k;
      assign latch_oe  = 1'b0;
      assign latch_bit = 1'b0;
    end else begin : g_latch
      logic latch_q, latch_d, latch_en;
      assign latch_en = cpu_wr & win_6k;
      assign latch_d  = cpu_data[0];
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)    latch_q <= 1'b0;
        else if (latch_en) latch_q <= latch_d;
      end
      assign wram_ce   = 1'b0;
      assign latch_oe  = cpu_rd & win_6k;
      assign latch_bit = LATCH_EN ? latch_q : 1'b0;

      // R11: latch captures data bit 0 of a window write
      p_latch_capture_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
        (LATCH_EN && cpu_wr && win_6k) |=> latch_bit == $past(cpu_data[0]));
    end
  endgenerate

  // R2: top 8 KB window is always the last bank
  p_last_slot_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_addr[15] && cpu_addr[14:13] == 2'd3) |-> prg_bank == '1);

  // R7: one-screen modes pin the nametable bit
  p_onescreen_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode[1] |-> ciram_a10 == mode[0]);
endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a_addr = '0, b_addr = '0;
  logic [7:0]  a_data = '0, b_data = '0;
  logic        a_wr = 0, b_wr = 0, a_rd = 0, b_rd = 0;
  logic [13:0] a_ppu = '0, b_ppu = '0;
  logic [4:0]  a_prg, b_prg;
  logic [7:0]  a_chr, b_chr;
  logic        a_cir, b_cir, a_wce, b_wce, a_loe, b_loe, a_lb, b_lb;
  logic [10:0] a_wa, b_wa;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(a_addr), .cpu_data(a_data),
    .cpu_wr(a_wr), .cpu_rd(a_rd), .ppu_addr(a_ppu), .prg_bank(a_prg),
    .chr_bank(a_chr), .ciram_a10(a_cir), .wram_ce(a_wce), .wram_addr(a_wa),
    .latch_oe(a_loe), .latch_bit(a_lb));

  bank_mapper #(
    .EXTENDED(1'b0), .MIRROR_HACK(1'b0), .CHR_SHIFT(1'b1), .LEGACY_OR(1'b1),
    .SEL_LO_BIT(0), .SEL_HI_BIT(1), .SEL_LO_ALT(6), .SEL_HI_ALT(7)
  ) dut_basic (
    .clk(clk), .rst_n(rst_n), .cpu_addr(b_addr), .cpu_data(b_data),
    .cpu_wr(b_wr), .cpu_rd(b_rd), .ppu_addr(b_ppu), .prg_bank(b_prg),
    .chr_bank(b_chr), .ciram_a10(b_cir), .wram_ce(b_wce), .wram_addr(b_wa),
    .latch_oe(b_loe), .latch_bit(b_lb));

  int checks = 0, fails = 0;
  bit done = 0;

  // models
  int m_p0, m_p1, m_swap, m_mode;
  int m_chr [8];
  int n_p0, n_p1, n_mode;
  int n_chr [8];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_prg(int slot, int p0, int p1, int sw);
    case (slot)
      0: return sw ? 30 : p0;
      1: return p1;
      2: return sw ? p0 : 30;
      default: return 31;
    endcase
  endfunction

  function automatic int exp_cir(int mode, int a10, int a11);
    case (mode)
      0: return a10;
      1: return a11;
      2: return 0;
      default: return 1;
    endcase
  endfunction

  // extended: select on A2 (bit0) and A3 (bit1)
  function automatic logic [15:0] ea(int g, int s, logic [15:0] noise);
    logic [15:0] r;
    r = 16'h8000 | 16'(g << 12) | (noise & 16'h0FF3);
    r[2] = s[0];
    r[3] = s[1];
    return r;
  endfunction

  // basic: select on A0/A1, or alternate A6/A7 when alt set
  function automatic logic [15:0] ba(int g, int s, bit alt);
    logic [15:0] r;
    r = 16'h8000 | 16'(g << 12);
    if (alt) begin r[6] = s[0]; r[7] = s[1]; end
    else     begin r[0] = s[0]; r[1] = s[1]; end
    return r;
  endfunction

  task automatic a_write(logic [15:0] addr, logic [7:0] d);
    @(negedge clk);
    a_addr = addr; a_data = d; a_wr = 1'b1;
    @(negedge clk);
    a_wr = 1'b0;
  endtask

  task automatic b_write(logic [15:0] addr, logic [7:0] d);
    @(negedge clk);
    b_addr = addr; b_data = d; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  // model of an extended write through group g / select s
  task automatic a_reg(int g, int s, logic [7:0] d, logic [15:0] noise);
    a_write(ea(g, s, noise), d);
    case (g)
      0: m_p0 = d[4:0];
      1: if (!s[1]) m_mode = (d == 8'hFF) ? int'(d[0]) : int'(d[1:0]);
         else m_swap = d[1];
      2: m_p1 = d[4:0];
      3, 4, 5, 6: begin
        int idx = ((g - 3) << 1) | s[1];
        if (!s[0]) m_chr[idx] = (m_chr[idx] & 8'hF0) | d[3:0];
        else       m_chr[idx] = (m_chr[idx] & 8'h0F) | (int'(d[3:0]) << 4);
      end
      default: ;
    endcase
  endtask

  task automatic b_reg(int g, int s, logic [7:0] d, bit alt);
    b_write(ba(g, s, alt), d);
    case (g)
      0: n_p0 = d[4:0];
      1: if (!s[1]) n_mode = d[0];
      2: n_p1 = d[4:0];
      3, 4, 5, 6: begin
        int idx = ((g - 3) << 1) | s[1];
        if (!s[0]) n_chr[idx] = (n_chr[idx] & 8'hF0) | d[3:0];
        else       n_chr[idx] = (n_chr[idx] & 8'h0F) | (int'(d[3:0]) << 4);
      end
      default: ;
    endcase
  endtask

  task automatic a_check_all(string req);
    for (int sl = 0; sl < 4; sl++) begin
      a_addr = 16'h8000 | 16'(sl << 13); #1;
      chk({req, " prg"}, a_prg, exp_prg(sl, m_p0, m_p1, m_swap));
    end
    for (int pg = 0; pg < 8; pg++) begin
      a_ppu = 14'(pg << 10); #1;
      chk({req, " chr"}, a_chr, m_chr[pg]);
    end
    for (int n = 0; n < 4; n++) begin
      a_ppu = 14'(n << 10); #1;
      chk({req, " ciram"}, a_cir, exp_cir(m_mode, n & 1, n >> 1));
    end
  endtask

  task automatic b_check_all(string req);
    for (int sl = 0; sl < 4; sl++) begin
      b_addr = 16'h8000 | 16'(sl << 13); #1;
      chk({req, " prg"}, b_prg, exp_prg(sl, n_p0, n_p1, 0));
    end
    for (int pg = 0; pg < 8; pg++) begin
      b_ppu = 14'(pg << 10); #1;
      chk({req, " chr"}, b_chr, n_chr[pg] >> 1);
    end
    for (int n = 0; n < 4; n++) begin
      b_ppu = 14'(n << 10); #1;
      chk({req, " ciram"}, b_cir, exp_cir(n_mode, n & 1, n >> 1));
    end
  endtask

  initial begin
    int seed;
    m_p0 = 0; m_p1 = 0; m_swap = 0; m_mode = 0;
    n_p0 = 0; n_p1 = 0; n_mode = 0;
    for (int i = 0; i < 8; i++) begin m_chr[i] = 0; n_chr[i] = 0; end
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    a_check_all("R1");
    b_check_all("R1");

    // R2 program banks, upper data bits dropped
    a_reg(0, 0, 8'hE5, 16'h0);
    a_reg(2, 1, 8'h09, 16'h0);
    a_check_all("R2");

    // R3 swap on, then off
    a_reg(1, 2, 8'h02, 16'h0);
    a_check_all("R3");
    a_reg(1, 3, 8'h00, 16'h0);
    a_check_all("R3");

    // R4 character nibbles for page 3
    a_reg(4, 2, 8'hFA, 16'h0);
    a_reg(4, 3, 8'h05, 16'h0);
    a_ppu = 14'(3 << 10); #1;
    chk("R4 page3", a_chr, 8'h5A);
    a_check_all("R4");

    // R6 non-select low bits ignored: A1:0 set, A3:2 = 0 -> page 0 low nibble
    a_reg(3, 0, 8'h07, 16'h0FF3);
    a_check_all("R6");

    // R7 all four mirroring modes
    for (int md = 0; md < 4; md++) begin
      a_reg(1, 0, 8'(md), 16'h0);
      a_check_all("R7");
    end

    // R9 $FF refused one-screen, $FE accepted
    a_reg(1, 1, 8'hFF, 16'h0);
    chk("R9 mode after FF", m_mode, 1);
    a_check_all("R9");
    a_reg(1, 0, 8'hFE, 16'h0);
    a_check_all("R9");

    // R12 writes outside registers
    a_write(16'hF00C, 8'h1F);
    a_write(16'h4000, 8'h1F);
    a_write(16'h6000, 8'h1F);
    a_check_all("R12");

    // R10 work RAM window
    @(negedge clk);
    a_addr = 16'h6123; #1;
    chk("R10 ce in", a_wce, 1);
    chk("R10 addr", a_wa, 11'h123);
    a_addr = 16'h7000; #1;
    chk("R10 ce 7000", a_wce, 0);
    a_addr = 16'h5FFF; #1;
    chk("R10 ce 5FFF", a_wce, 0);
    b_addr = 16'h6000; #1;
    chk("R10 basic ce", b_wce, 0);

    // basic variant: R5 shift, R6 legacy OR, R8 two-way, R3 ignored swap
    b_reg(0, 0, 8'h07, 1'b0);
    b_reg(3, 0, 8'h0A, 1'b1);
    b_reg(6, 3, 8'h03, 1'b0);
    b_reg(6, 2, 8'h0C, 1'b1);
    b_check_all("R5");
    b_ppu = 14'(7 << 10); #1;
    chk("R6 legacy page7", b_chr, 8'h3C >> 1);
    b_reg(1, 0, 8'h03, 1'b0);
    b_check_all("R8");
    b_reg(1, 2, 8'h02, 1'b1);
    b_check_all("R3 basic");

    // R11 latch
    b_write(16'h6000, 8'h01);
    @(negedge clk);
    b_addr = 16'h6ABC; b_rd = 1'b1; #1;
    chk("R11 oe", b_loe, 1);
    chk("R11 bit1", b_lb, 1);
    b_rd = 1'b0;
    b_write(16'h7000, 8'h00);
    @(negedge clk);
    b_addr = 16'h7000; b_rd = 1'b1; #1;
    chk("R11 oe 7000", b_loe, 0);
    b_addr = 16'h6001; #1;
    chk("R11 7000 ignored", b_lb, 1);
    b_rd = 1'b0;
    b_write(16'h6FFF, 8'hFE);
    @(negedge clk);
    b_addr = 16'h6000; b_rd = 1'b1; #1;
    chk("R11 bit0", b_lb, 0);
    b_rd = 1'b0;

    // random traffic on the extended variant
    for (int it = 0; it < 400; it++) begin
      int g, s;
      logic [7:0] d;
      logic [15:0] noise;
      g = $urandom_range(0, 7);
      s = $urandom_range(0, 3);
      d = 8'($urandom);
      noise = 16'($urandom);
      if ($urandom_range(0, 9) == 0) d = 8'hFF;
      a_reg(g, s, d, noise);
      if (it % 8 == 7) a_check_all("R2/R4/R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule